// File: doc/BRIEF.md
# Tag-Chain Address Sequencer

This block steps a DMA channel through a linked list of 128-bit descriptors (tags) held in memory. Each time a tag has been fetched, the fetch logic presents the tag's 3-bit kind, its quadword count and its pointer field with a one-cycle valid strobe. The sequencer then computes where the payload of that tag lives (the data address), where the next tag is to be fetched from (the tag address), and whether the list is finished. Addresses are byte addresses, and one quadword is 16 bytes. "After the tag" therefore means tag address + 16, and a payload block covers count × 16 bytes.

When the stack mode is enabled, a two-slot return stack lets a tag branch into a sub-list and a later tag come back to the tag that follows the caller's payload. Pushing onto a full stack ends the chain, and so does popping an empty stack. The block does not move data, arbitrate for the bus or handle stall control.

The control is a two-state machine. In ST_IDLE, tags are ignored. The transition START (the start input) loads the tag address and enters ST_RUN. In ST_RUN, tags are accepted. The transition FINISH (an accepted tag that ends the chain) returns to ST_IDLE. START takes priority over everything else in either state.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, data_addr = 0, next_tag_addr = 0, stack_depth = 0, chain_done = 0, and the machine is in ST_IDLE.
- R2: A cycle with start high loads next_tag_addr from start_addr, clears data_addr, empties the return stack (stack_depth = 0) and enters ST_RUN. All results become visible after the clock edge that samples start. start has priority over tag_valid.
- R3: Kind 1 (inline): data_addr = T+16 and next_tag_addr = T+16+count×16, where T is the tag address before the tag. The chain continues.
- R4: Kind 2 (jump): data_addr = T+16 and next_tag_addr = pointer. The chain continues.
- R5: Kind 3 (pointer) and kind 4 (pointer with stall): data_addr = pointer and next_tag_addr = T+16. The chain continues. Address arithmetic wraps modulo 2^AW.
- R6: Kind 0 (last pointer): data_addr = pointer, next_tag_addr is unchanged, and the chain ends.
- R7: Kind 7 (last inline): data_addr = T+16, next_tag_addr is unchanged (not advanced), and the chain ends.
- R8: Kind 5 (call) with the stack mode on, a nonzero pointer and stack_depth < 2: data_addr = T+16. The value T+16+count×16 is pushed, stack_depth increments, and next_tag_addr = pointer.
- R9: A call with stack_depth = 2 is an overflow. data_addr = T+16, next_tag_addr and stack_depth are unchanged, and the chain ends.
- R10: A call whose pointer is 0 acts as an inline tag (R3). Nothing is pushed, and this holds even with a full stack.
- R11: Kind 6 (return) with the stack mode on: data_addr = T+16. At depth 2, next_tag_addr gets the second pushed value. At depth 1, it gets the first pushed value. The popped slot is zeroed and the depth decrements. At depth 0, next_tag_addr is unchanged and the chain ends.
- R12: With stack_en low, call and return tags are ignored. data_addr, next_tag_addr and stack_depth do not change, and chain_done stays low.
- R13: chain_done is a one-cycle pulse in the cycle after the ending tag. After it, the machine is in ST_IDLE and ignores tags until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new chain |
| start_addr | input | AW | Address of the first tag |
| tag_valid | input | 1 | A fetched tag is presented this cycle |
| tag_kind | input | 3 | Kind of the tag (encodings in R3 to R11) |
| tag_qwc | input | QW | Payload length in quadwords |
| tag_ptr | input | AW | Pointer field of the tag |
| stack_en | input | 1 | Enables call/return tags |
| data_addr | output | AW | Payload address |
| next_tag_addr | output | AW | Address of the next tag to fetch |
| stack_depth | output | 2 | Number of return addresses held |
| chain_done | output | 1 | One-cycle end-of-chain pulse |

## Verification
The bench builds the block with AW = 32 and QW = 16. With these widths, a count of 0xFFFF shifts payload lengths into bits well above the low address bits. A tag at 0xFFFFFFF0 also lets the +16 step wrap the address to zero. The vector walk runs a nested chain that fills the stack to depth 2, tries call and return with the stack mode off, and then unwinds in order. The directed cases cover overflow, underflow, the zero-pointer call on a full stack, idle-state tags, and start clearing a full stack.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        TK_PTR_LAST    = 3'd0,
        TK_INLINE      = 3'd1,
        TK_JUMP        = 3'd2,
        TK_PTR         = 3'd3,
        TK_PTR_STALL   = 3'd4,
        TK_CALL        = 3'd5,
        TK_RETURN      = 3'd6,
        TK_INLINE_LAST = 3'd7
    } tag_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/dma_ret_stack.sv
module dma_ret_stack #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [1:0]    depth,
    output logic [AW-1:0] top_val
);
    localparam int SLOTS = 2;

    logic [AW-1:0] slot_q [SLOTS];
    logic [1:0]    depth_q;
    logic          wr_idx;
    logic          rd_idx;

    assign wr_idx  = depth_q[0];
    assign rd_idx  = ~depth_q[0];
    assign depth   = depth_q;
    assign top_val = (depth_q == 2'd2) ? slot_q[1] : slot_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= 2'd0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (clear) begin
            depth_q <= 2'd0;
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else if (push && (depth_q < 2'(SLOTS))) begin
            slot_q[wr_idx] <= push_val;
            depth_q        <= depth_q + 2'd1;
        end else if (pop && (depth_q != 2'd0) && (depth_q <= 2'(SLOTS))) begin
            slot_q[rd_idx] <= '0;
            depth_q        <= depth_q - 2'd1;
        end
    end

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (depth_q < 2'd2)); // R9

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear && depth_q == 2'd2) |=> (depth_q == 2'd1)); // R11

endmodule

// File: rtl/dma_tag_decode.sv
module dma_tag_decode
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 16
) (
    input  tag_kind_e     kind,
    input  logic [QW-1:0] qwc,
    input  logic [AW-1:0] tag_ptr,
    input  logic [AW-1:0] cur_tag,
    input  logic [AW-1:0] cur_data,
    input  logic [1:0]    depth,
    input  logic [AW-1:0] top_val,
    input  logic          stack_en,
    output logic [AW-1:0] data_nx,
    output logic [AW-1:0] tag_nx,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] push_val,
    output logic          done
);
    localparam int QBYTES = 16;

    logic [AW-1:0] follow;
    logic [AW-1:0] span;

    assign follow   = cur_tag + AW'(QBYTES);
    assign span     = AW'({qwc, 4'b0000});
    assign push_val = follow + span;

    always_comb begin
        data_nx = tag_ptr;
        tag_nx  = cur_tag;
        push    = 1'b0;
        pop     = 1'b0;
        done    = 1'b0;
        unique case (kind)
            TK_PTR_LAST: done = 1'b1;
            TK_INLINE: begin
                data_nx = follow;
                tag_nx  = follow + span;
            end
            TK_JUMP: begin
                data_nx = follow;
                tag_nx  = tag_ptr;
            end
            TK_PTR, TK_PTR_STALL: tag_nx = follow;
            TK_CALL: begin
                if (!stack_en) begin
                    data_nx = cur_data;
                end else begin
                    data_nx = follow;
                    if (tag_ptr == '0) begin
                        tag_nx = follow + span;
                    end else if (depth >= 2'd2) begin
                        done = 1'b1;
                    end else begin
                        push   = 1'b1;
                        tag_nx = tag_ptr;
                    end
                end
            end
            TK_RETURN: begin
                if (!stack_en) begin
                    data_nx = cur_data;
                end else begin
                    data_nx = follow;
                    if (depth == 2'd1 || depth == 2'd2) begin
                        pop    = 1'b1;
                        tag_nx = top_val;
                    end else begin
                        done = 1'b1;
                    end
                end
            end
            TK_INLINE_LAST: begin
                data_nx = follow;
                done    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_chain_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          tag_valid,
    input  logic [2:0]    tag_kind,
    input  logic [QW-1:0] tag_qwc,
    input  logic [AW-1:0] tag_ptr,
    input  logic          stack_en,
    output logic [AW-1:0] data_addr,
    output logic [AW-1:0] next_tag_addr,
    output logic [1:0]    stack_depth,
    output logic          chain_done
);
    seq_state_e    state_q, state_nx;
    tag_kind_e     kind;
    logic          accept;
    logic [AW-1:0] data_nx, tag_nx, push_val, top_val;
    logic          push, pop, done;

    assign kind   = tag_kind_e'(tag_kind);
    assign accept = (state_q == ST_RUN) && tag_valid && !start;

    dma_tag_decode #(.AW(AW), .QW(QW)) u_dec (
        .kind    (kind),
        .qwc     (tag_qwc),
        .tag_ptr (tag_ptr),
        .cur_tag (next_tag_addr),
        .cur_data(data_addr),
        .depth   (stack_depth),
        .top_val (top_val),
        .stack_en(stack_en),
        .data_nx (data_nx),
        .tag_nx  (tag_nx),
        .push    (push),
        .pop     (pop),
        .push_val(push_val),
        .done    (done)
    );

    dma_ret_stack #(.AW(AW)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .push    (accept && push),
        .pop     (accept && pop),
        .push_val(push_val),
        .depth   (stack_depth),
        .top_val (top_val)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (!start && accept && done) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_addr     <= '0;
            next_tag_addr <= '0;
            chain_done    <= 1'b0;
        end else if (start) begin
            data_addr     <= '0;
            next_tag_addr <= start_addr;
            chain_done    <= 1'b0;
        end else begin
            chain_done <= accept && done;
            if (accept) begin
                data_addr     <= data_nx;
                next_tag_addr <= tag_nx;
            end
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> ($stable(next_tag_addr) && $stable(data_addr) && !chain_done)); // R13

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> !chain_done); // R13

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (stack_depth == 2'd0 && next_tag_addr == $past(start_addr))); // R2

    AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == TK_INLINE_LAST) |=> (chain_done && next_tag_addr == $past(next_tag_addr))); // R7

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == TK_JUMP) |=> (next_tag_addr == $past(tag_ptr))); // R4

    AST_NOSTACK_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !stack_en && (kind == TK_CALL || kind == TK_RETURN))
        |=> ($stable(next_tag_addr) && $stable(data_addr) && $stable(stack_depth) && !chain_done)); // R12

endmodule

// File: tb/tb_dma_chain_seq.sv
module tb_dma_chain_seq;
    localparam int AW = 32;
    localparam int QW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          tag_valid = 1'b0;
    logic [2:0]    tag_kind = '0;
    logic [QW-1:0] tag_qwc = '0;
    logic [AW-1:0] tag_ptr = '0;
    logic          stack_en = 1'b0;
    logic [AW-1:0] data_addr, next_tag_addr;
    logic [1:0]    stack_depth;
    logic          chain_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_chain_seq #(.AW(AW), .QW(QW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .tag_valid(tag_valid), .tag_kind(tag_kind), .tag_qwc(tag_qwc),
        .tag_ptr(tag_ptr), .stack_en(stack_en), .data_addr(data_addr),
        .next_tag_addr(next_tag_addr), .stack_depth(stack_depth),
        .chain_done(chain_done)
    );

    // kind(3) qwc(16) ptr(32) en(1) exp_data(32) exp_tag(32) exp_depth(2) exp_done(1)
    localparam int VW = 119;
    localparam int NV = 13;
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'd1, 16'd2,      32'h000dead0, 1'b1, 32'h00001010, 32'h00001030, 2'd0, 1'b0}, // R3
        {3'd2, 16'd1,      32'h00002000, 1'b1, 32'h00001040, 32'h00002000, 2'd0, 1'b0}, // R4
        {3'd3, 16'd3,      32'h00008000, 1'b1, 32'h00008000, 32'h00002010, 2'd0, 1'b0}, // R5
        {3'd4, 16'd0,      32'h00009000, 1'b1, 32'h00009000, 32'h00002020, 2'd0, 1'b0}, // R5
        {3'd5, 16'd4,      32'h00003000, 1'b1, 32'h00002030, 32'h00003000, 2'd1, 1'b0}, // R8
        {3'd5, 16'd1,      32'h00004000, 1'b1, 32'h00003010, 32'h00004000, 2'd2, 1'b0}, // R8
        {3'd5, 16'd5,      32'h00005000, 1'b0, 32'h00003010, 32'h00004000, 2'd2, 1'b0}, // R12
        {3'd6, 16'd0,      32'h00006000, 1'b0, 32'h00003010, 32'h00004000, 2'd2, 1'b0}, // R12
        {3'd5, 16'd2,      32'h00000000, 1'b1, 32'h00004010, 32'h00004030, 2'd2, 1'b0}, // R10
        {3'd6, 16'd0,      32'h00000000, 1'b1, 32'h00004040, 32'h00003020, 2'd1, 1'b0}, // R11
        {3'd6, 16'd0,      32'h00000000, 1'b1, 32'h00003030, 32'h00002070, 2'd0, 1'b0}, // R11
        {3'd1, 16'hffff,   32'h00000000, 1'b1, 32'h00002080, 32'h00102070, 2'd0, 1'b0}, // R3
        {3'd7, 16'd0,      32'h00000000, 1'b1, 32'h00102080, 32'h00102070, 2'd0, 1'b1}  // R7
    };

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [AW-1:0] ed, input logic [AW-1:0] et,
                           input logic [1:0] es, input logic ee);
        chk({req, " data_addr"}, data_addr, ed);
        chk({req, " next_tag_addr"}, next_tag_addr, et);
        chk({req, " stack_depth"}, AW'(stack_depth), AW'(es));
        chk({req, " chain_done"}, AW'(chain_done), AW'(ee));
    endtask

    task automatic do_start(input logic [AW-1:0] a);
        start = 1'b1; start_addr = a;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_tag(input logic [2:0] k, input logic [QW-1:0] q,
                          input logic [AW-1:0] p, input logic en);
        tag_valid = 1'b1; tag_kind = k; tag_qwc = q; tag_ptr = p; stack_en = en;
        @(posedge clk); @(negedge clk);
        tag_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 32'h0, 32'h0, 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: tags ignored while idle
        do_tag(3'd1, 16'd4, 32'h0, 1'b1);
        chk_all("R13 idle ignore", 32'h0, 32'h0, 2'd0, 1'b0);

        // R2: start loads tag address
        do_start(32'h00001000);
        chk_all("R2 start", 32'h0, 32'h00001000, 2'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            do_tag(v[118:116], v[115:100], v[99:68], v[67]);
            chk_all($sformatf("vector %0d", i), v[66:35], v[34:3], v[2:1], v[0]);
        end
        @(negedge clk);
        chk("R13 pulse one cycle", AW'(chain_done), 32'h0);
        do_tag(3'd1, 16'd1, 32'h0, 1'b1);
        chk("R13 ignored after end", next_tag_addr, 32'h00102070);

        // R6: last pointer
        do_start(32'h00000500);
        do_tag(3'd0, 16'd2, 32'h00007000, 1'b1);
        chk_all("R6 last ptr", 32'h00007000, 32'h00000500, 2'd0, 1'b1);

        // R9: overflow
        do_start(32'h00000100);
        do_tag(3'd5, 16'd0, 32'h00000200, 1'b1);
        chk_all("R8 call1", 32'h00000110, 32'h00000200, 2'd1, 1'b0);
        do_tag(3'd5, 16'd0, 32'h00000300, 1'b1);
        chk_all("R8 call2", 32'h00000210, 32'h00000300, 2'd2, 1'b0);
        do_tag(3'd5, 16'd1, 32'h00000000, 1'b1);
        chk_all("R10 zero ptr full stack", 32'h00000310, 32'h00000320, 2'd2, 1'b0);
        do_tag(3'd5, 16'd1, 32'h00000400, 1'b1);
        chk_all("R9 overflow", 32'h00000330, 32'h00000320, 2'd2, 1'b1);

        // R2 start clears full stack, then R11 underflow
        do_start(32'h00000600);
        chk_all("R2 restart clears", 32'h0, 32'h00000600, 2'd0, 1'b0);
        do_tag(3'd6, 16'd0, 32'h0, 1'b1);
        chk_all("R11 underflow", 32'h00000610, 32'h00000600, 2'd0, 1'b1);

        // R5: wrap
        do_start(32'hfffffff0);
        do_tag(3'd3, 16'd0, 32'h00000010, 1'b1);
        chk_all("R5 wrap", 32'h00000010, 32'h00000000, 2'd0, 1'b0);

        // R2: start has priority over a tag in the same cycle
        start = 1'b1; start_addr = 32'h00000a00;
        tag_valid = 1'b1; tag_kind = 3'd7; tag_qwc = '0; tag_ptr = '0;
        @(posedge clk); @(negedge clk);
        start = 1'b0; tag_valid = 1'b0;
        chk_all("R2 start priority", 32'h0, 32'h00000a00, 2'd0, 1'b0);

        finish_run();
    end
endmodule